// File: doc/BRIEF.md
# CPU Single-Step Wait Controller

This block lets software on an 8-bit processor be halted and advanced one instruction at a time. It watches the processor's active-low opcode-fetch strobe (`m1N`) to find where each instruction begins. It pauses the processor by pulling the active-low wait input (`waitN`) low during that fetch. The processor clock keeps running the whole time.

A Run/Stop switch chooses between free running and stepped operation. In Stop mode every fetch is held until the operator toggles the Step input, and each toggle lets exactly one fetch complete. Both operator inputs arrive from mechanical switches. Each one passes through a two-flop synchroniser and a counter debouncer sized for a 4 MHz clock before the control logic uses it.

The processor is assumed to run on the same clock as this block, so `m1N` is used without a synchroniser. `waitN` is formed combinationally from `m1N` so that it is valid within the same clock as the start of the fetch.

Top module: `step_wait_ctrl`

## Requirements
- R1: `waitN` is driven low only while `m1N` is low (a fetch is in progress); with `m1N` high, `waitN` is high.
- R2: While the debounced Run/Stop level is 1 (Run), `waitN` is never low and the processor fetches without interruption.
- R3: While the debounced level is 0 (Stop), a fetch that starts is held with `waitN` low. Each low-to-high transition of the debounced Step level lets exactly one held fetch complete.
- R4: A step release lasts only until `m1N` returns high and is then re-armed. A Step level held high for any length of time releases exactly one instruction.
- R5: A change from Stop to Run releases a held fetch as soon as the debounced Run level is seen, even in the middle of a fetch.
- R6: A change from Run to Stop takes effect at the next fetch. Once `waitN` has been high during a fetch, it stays high until `m1N` rises.
- R7: Step transitions made while in Run mode are discarded and release nothing after a later switch to Stop.
- R8: Each operator input passes through `SYNC_STAGES` flops, and its level is accepted only after it has differed from the current accepted level for `DEB_CYCLES` consecutive clocks. The default of 40000 cycles is 10 ms at 4 MHz. Shorter pulses are ignored.
- R9: The synchronous active-high `rst` clears any pending step and forces `waitN` high while it is asserted. Both debounced levels restart at 0, so the block comes out of reset in Stop mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor/system clock |
| rst | input | 1 | Synchronous reset, active high |
| runSwRaw | input | 1 | Raw Run/Stop switch, 1 = Run, 0 = Stop |
| stepRaw | input | 1 | Raw Step switch; a low-to-high toggle requests one instruction |
| m1N | input | 1 | Processor opcode-fetch strobe, active low |
| waitN | output | 1 | Wait request to the processor, active low |

## Verification
On every cycle, the embedded properties check four things:
- `waitN` stays inside fetch cycles.
- A fetch that has been let go is never caught again before it ends.
- Each step release is backed by a pending request and ends with the fetch.
- A debounced level only ever moves to the value the synchroniser presents.

Other behaviour needs a model of the processor that counts completed fetches, so only the bench scenarios can show it. That includes exactly one instruction per toggle regardless of how long Step is held, rejection of short glitches, and step presses in Run mode leaving no stale release. The immediate release on a Stop-to-Run change is also shown only by these scenarios.

// File: rtl/step_wait_pkg.sv
package step_wait_pkg;

  // Channel indices of the operator inputs.
  localparam int CH_RUN  = 0;
  localparam int CH_STEP = 1;
  localparam int N_CH    = 2;

  // Conditioned operator strobes handed from datapath to control.
  typedef struct packed {
    logic runLvl;    // debounced Run/Stop level, 1 = Run
    logic stepRise;  // one-cycle pulse on a debounced Step low-to-high edge
  } condT;

endpackage

// File: rtl/step_wait_deb.sv
module step_wait_deb #(
  parameter int DEB_CYCLES  = 40000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rawIn,
  output logic levelOut
);
  localparam int CW = $clog2(DEB_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(DEB_CYCLES - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [CW-1:0]          quietCnt;
  logic                   syncLast;

  assign syncLast = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      syncQ    <= '0;
      quietCnt <= '0;
      levelOut <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], rawIn};
      if (syncLast == levelOut) begin
        quietCnt <= '0;
      end else if (quietCnt == LAST) begin
        quietCnt <= '0;
        levelOut <= syncLast;
      end else begin
        quietCnt <= quietCnt + 1'b1;
      end
    end
  end

  // R8: the accepted level only moves to what the synchroniser presented.
  p_level_from_sync_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(levelOut) |-> (levelOut == $past(syncLast)));

endmodule

// File: rtl/step_wait_dp.sv
module step_wait_dp
  import step_wait_pkg::*;
#(
  parameter int DEB_CYCLES  = 40000,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_CH-1:0] rawIn,
  output condT            cond
);
  logic [N_CH-1:0] lvl;
  logic            stepLvlQ;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
    step_wait_deb #(
      .DEB_CYCLES (DEB_CYCLES),
      .SYNC_STAGES(SYNC_STAGES)
    ) deb_i (
      .clk     (clk),
      .rst     (rst),
      .rawIn   (rawIn[ch]),
      .levelOut(lvl[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) stepLvlQ <= 1'b0;
    else     stepLvlQ <= lvl[CH_STEP];
  end

  assign cond.runLvl   = lvl[CH_RUN];
  assign cond.stepRise = lvl[CH_STEP] & ~stepLvlQ;

  // R3: a step strobe is a single-cycle pulse.
  p_step_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    cond.stepRise |=> !cond.stepRise);

endmodule

// File: rtl/step_wait_ctl.sv
module step_wait_ctl
  import step_wait_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  condT cond,
  input  logic m1N,
  output logic waitN
);
  logic stepPending;
  logic grant;
  logic latchedRun;

  always_ff @(posedge clk) begin
    if (rst) begin
      stepPending <= 1'b0;
      grant       <= 1'b0;
      latchedRun  <= 1'b0;
    end else begin
      // Mode seen at the start of a fetch; sticky toward Run within a fetch.
      latchedRun <= m1N ? cond.runLvl : (latchedRun | cond.runLvl);

      if (m1N)                       grant <= 1'b0;
      else if (!grant && stepPending) grant <= 1'b1;

      if (cond.runLvl)                          stepPending <= 1'b0;
      else if (cond.stepRise)                   stepPending <= 1'b1;
      else if (!m1N && !grant && stepPending)   stepPending <= 1'b0;
    end
  end

  assign waitN = rst | m1N | cond.runLvl | latchedRun | grant;

  // R1: wait only inside a fetch.
  p_wait_in_fetch_r1: assert property (@(posedge clk) disable iff (rst)
    m1N |-> waitN);

  // R6: once released inside a fetch, never caught again in that fetch.
  p_no_rehold_r6: assert property (@(posedge clk) disable iff (rst)
    (!m1N && $past(!m1N) && $past(waitN)) |-> waitN);

  // R4: every release is backed by a pending request.
  p_grant_backed_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(grant) |-> $past(stepPending));

  // R4: release is re-armed when the fetch ends.
  p_grant_rearm_r4: assert property (@(posedge clk) disable iff (rst)
    m1N |=> !grant);

  // R7: no request survives Run mode.
  p_run_drops_step_r7: assert property (@(posedge clk) disable iff (rst)
    cond.runLvl |=> !stepPending);

  // R9: reset clears pending and release state.
  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (!stepPending && !grant));

  always_comb begin
    if (rst) p_reset_wait_high_r9: assert (waitN);
  end

endmodule

// File: rtl/step_wait_ctrl.sv
module step_wait_ctrl
  import step_wait_pkg::*;
#(
  parameter int DEB_CYCLES  = 40000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic runSwRaw,
  input  logic stepRaw,
  input  logic m1N,
  output logic waitN
);
  condT            cond;
  logic [N_CH-1:0] rawIn;

  always_comb begin
    rawIn          = '0;
    rawIn[CH_RUN]  = runSwRaw;
    rawIn[CH_STEP] = stepRaw;
  end

  step_wait_dp #(
    .DEB_CYCLES (DEB_CYCLES),
    .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk  (clk),
    .rst  (rst),
    .rawIn(rawIn),
    .cond (cond)
  );

  step_wait_ctl ctl_i (
    .clk  (clk),
    .rst  (rst),
    .cond (cond),
    .m1N  (m1N),
    .waitN(waitN)
  );

endmodule

// File: tb/step_wait_ctrl_tb_top.sv
module step_wait_ctrl_tb_top;
  localparam int DEB = 8;

  typedef struct packed {
    logic [7:0] nSteps;
    logic [7:0] holdLen;
    logic [7:0] expDelta;
  } vecT;

  // Stop-mode step vectors: presses, high time per press, expected fetches.
  localparam vecT VECS [6] = '{
    '{8'd1, 8'd20,  8'd1},   // R3 single toggle
    '{8'd0, 8'd20,  8'd0},   // R3 no toggle, stays held
    '{8'd2, 8'd20,  8'd2},   // R3 two toggles
    '{8'd3, 8'd20,  8'd3},   // R3 three toggles
    '{8'd1, 8'd100, 8'd1},   // R4 long hold releases one
    '{8'd1, 8'd3,   8'd0}    // R8 glitch shorter than debounce
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic runSwRaw = 1'b0;
  logic stepRaw = 1'b0;
  logic m1N = 1'b1;
  logic waitN;

  int addr = 0;
  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  step_wait_ctrl #(.DEB_CYCLES(DEB), .SYNC_STAGES(2)) dut_i (
    .clk     (clk),
    .rst     (rst),
    .runSwRaw(runSwRaw),
    .stepRaw (stepRaw),
    .m1N     (m1N),
    .waitN   (waitN)
  );

  // CPU model: fetches NOP forever, two idle clocks between fetches,
  // a fetch ends once at least two clocks in with waitN high.
  initial begin
    int idle = 0;
    int tcnt = 0;
    forever begin
      @(negedge clk);
      if (m1N) begin
        idle++;
        if (idle >= 2) begin m1N = 1'b0; tcnt = 0; end
      end else begin
        tcnt++;
        if (tcnt >= 2 && waitN) begin m1N = 1'b1; addr++; idle = 0; end
      end
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic press(input int hold);
    stepRaw = 1'b1; wait_cyc(hold);
    stepRaw = 1'b0; wait_cyc(20);
  endtask

  initial begin
    #2_000_000;
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    int base;
    int lows;
    int releases;
    bit wasHeld;

    // R9: reset forces waitN high; block leaves reset in Stop.
    wait_cyc(1);
    check(waitN == 1'b1, "R9 waitN high in reset", waitN, 1);
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(12);
    check(m1N == 1'b0 && waitN == 1'b0, "R9/R3 held after reset", waitN, 0);
    check(m1N == 1'b0, "R1 hold inside fetch", m1N, 0);

    // Vector table: stop-mode stepping.
    for (int v = 0; v < 6; v++) begin
      base = addr;
      for (int k = 0; k < int'(VECS[v].nSteps); k++) press(int'(VECS[v].holdLen));
      wait_cyc(20);
      check(addr - base == int'(VECS[v].expDelta), $sformatf("R3/R4/R8 vector %0d", v),
            addr - base, int'(VECS[v].expDelta));
      check(waitN == 1'b0, $sformatf("R3 held after vector %0d", v), waitN, 0);
    end

    // R5: Stop to Run releases the held fetch once debounced.
    base = addr;
    runSwRaw = 1'b1;
    wait_cyc(DEB + 4);
    check(waitN == 1'b1, "R5 release on Run", waitN, 1);
    wait_cyc(20);
    check(addr - base > 0, "R5 CPU advances", addr - base, 1);

    // R2: Run mode never waits; CPU keeps going.
    base = addr;
    lows = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (!waitN) lows++;
    end
    check(lows == 0, "R2 no wait in Run", lows, 0);
    check(addr - base >= 10, "R2 continuous fetch", addr - base, 10);

    // R7: step pressed in Run, then Stop; no held fetch may be released.
    press(20);
    runSwRaw = 1'b0;
    wasHeld = 1'b0;
    releases = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (m1N) wasHeld = 1'b0;
      else if (!waitN) wasHeld = 1'b1;
      else if (wasHeld) begin releases++; wasHeld = 1'b0; end
    end
    check(releases == 0, "R7 run-mode step discarded", releases, 0);
    check(waitN == 1'b0 && m1N == 1'b0, "R6 Stop takes hold at next fetch", waitN, 0);

    // R1: between fetches, waitN high; after one step the CPU is idle briefly.
    base = addr;
    press(20);
    check(addr - base == 1, "R3 single step after Run", addr - base, 1);

    // R8: Run glitch shorter than debounce does not release.
    base = addr;
    runSwRaw = 1'b1; wait_cyc(3); runSwRaw = 1'b0;
    wait_cyc(30);
    check(addr - base == 0, "R8 run glitch ignored", addr - base, 0);

    // R9: reset mid-hold, then still in Stop with no stale release.
    rst = 1'b1; wait_cyc(3);
    check(waitN == 1'b1, "R9 waitN high in reset", waitN, 1);
    rst = 1'b0; wait_cyc(20);
    base = addr; wait_cyc(40);
    check(addr - base == 0, "R9 Stop after reset", addr - base, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule